// File: doc/BRIEF.md
# Spin-Lock Requester with Exponential Backoff

This block obtains and gives back a single-word lock in shared memory for one client core. When the client asks for the lock, the engine polls the lock word with plain reads. It keeps polling for as long as the word reads as taken. Only after a read shows the word free does it issue an atomic exchange that stores the taken value. The old value that comes back from the exchange decides the result. If the old value was free, the lock is now owned by this client. If it was taken, another requester got there first.

Every unsuccessful check starts a pause before the next read. A check is unsuccessful when a read shows the word taken or when an exchange returns a taken old value. The pause starts at a programmable minimum. It doubles after each unsuccessful check and stops growing at a programmable maximum. Early retries therefore come quickly, and a long wait backs off. When the client gives the lock back, the engine writes the free value to the lock word.

The memory side is a single-word request port with a valid/ready handshake and a one-cycle response strobe. At most one operation is in flight at any time.

Top module: `spin_lock_requester`

## Requirements
- R1: After synchronous reset, `grant`, `lock_held` and `mem_req_valid` are all low.
- R2: Every memory request targets the address given by parameter `LOCK_ADDR`. The first request after an accepted acquire is a plain read (op code 0). Reads repeat while the value returned is nonzero (1 = taken, 0 = free).
- R3: An exchange (op code 2, write data 1) is issued only as the next request after a read that returned 0.
- R4: `grant` is high for exactly one cycle. It rises the cycle after the response to an exchange that returned 0. `lock_held` is high in that same cycle and stays high until a release is accepted.
- R5: A read returning nonzero, or an exchange returning nonzero, is a failed check. After a failed check the next request is a plain read. Its valid rises W+1 cycles after the response cycle, where W is the current backoff interval (W is taken as 1 if the interval is 0).
- R6: The interval is `bo_min` for the first failed check of an acquire. After each failed check it becomes min(2×interval, `bo_max`). Doubling beyond the counter width still clamps to `bo_max`.
- R7: After a successful acquire the interval returns to `bo_min`, so the first failure of the next acquire waits `bo_min`.
- R8: A `rel_req` pulse while `lock_held` is high issues a write (op code 1) of 0 to the lock word. `lock_held` falls on the next cycle.
- R9: `rel_req` while the lock is not held, and `acq_req` while an acquire or hold is in progress, have no effect: no memory request is issued and `lock_held` is unchanged.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with the same op. No request is valid while a response is still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_req | input | 1 | Acquire pulse, accepted when idle |
| rel_req | input | 1 | Release pulse, accepted while the lock is held |
| bo_min | input | CNT_W | Starting backoff interval in cycles |
| bo_max | input | CNT_W | Ceiling of the backoff interval |
| grant | output | 1 | One-cycle pulse when the lock is obtained |
| lock_held | output | 1 | Lock is owned by this client |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_op | output | 2 | 0 read, 1 write, 2 atomic exchange |
| mem_req_addr | output | ADDR_W | Lock word address |
| mem_req_wdata | output | DATA_W | Write or exchange data |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | DATA_W | Read data or old value of an exchange |

## Verification
The bench builds the block with a 5-bit interval counter, so the largest interval is 31. Setting `bo_min` to 24 makes the first doubling produce 48, which does not fit in the counter; this exercises the clamp at the top of the counter range. Short ceilings such as 20 bring saturation within a few failures. A contending owner in the memory model, which sometimes grabs the word between the free read and the exchange, produces both kinds of failed check with random ready stalls.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;

    typedef enum logic [1:0] {
        MEM_READ  = 2'd0,
        MEM_WRITE = 2'd1,
        MEM_XCHG  = 2'd2
    } mem_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_POLL_REQ,
        ST_POLL_WAIT,
        ST_SWAP_REQ,
        ST_SWAP_WAIT,
        ST_PAUSE,
        ST_OWNED,
        ST_FREE_REQ,
        ST_FREE_WAIT
    } lk_state_e;

    typedef struct packed {
        logic    valid;
        mem_op_e op;
        logic    set_one;
    } lock_req_t;

    function automatic lock_req_t req_for_state(lk_state_e st);
        lock_req_t r;
        r.valid   = 1'b0;
        r.op      = MEM_READ;
        r.set_one = 1'b0;
        case (st)
            ST_POLL_REQ: r.valid = 1'b1;
            ST_SWAP_REQ: begin r.valid = 1'b1; r.op = MEM_XCHG; r.set_one = 1'b1; end
            ST_FREE_REQ: begin r.valid = 1'b1; r.op = MEM_WRITE; end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spl_backoff.sv
module spl_backoff #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] bo_min,
    input  logic [CNT_W-1:0] bo_max,
    input  logic             restart,
    input  logic             fail,
    input  logic             pausing,
    output logic             expired
);
    localparam int DBL_W = CNT_W + 1;

    logic [CNT_W-1:0] iv_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DBL_W-1:0] dbl;
    logic [CNT_W-1:0] iv_next;

    always_comb begin
        dbl = {1'b0, iv_q} << 1;
        if (dbl > {1'b0, bo_max}) iv_next = bo_max;
        else                      iv_next = dbl[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iv_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (restart)   iv_q <= bo_min;
            else if (fail) iv_q <= iv_next;
            if (fail)                          cnt_q <= iv_q;
            else if (pausing && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = pausing && (cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1});

    assert_iv_capped_R6: assert property (@(posedge clk) disable iff (rst)
        (fail && !restart && iv_q != '0) |=> (iv_q <= $past(bo_max) || iv_q == $past(bo_min)));

    assert_pause_loaded_R5: assert property (@(posedge clk) disable iff (rst)
        fail |=> (cnt_q == $past(iv_q)));

endmodule

// File: rtl/spl_ctrl.sv
module spl_ctrl
    import spinlock_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      acq_req,
    input  logic      rel_req,
    input  logic      mem_req_ready,
    input  logic      mem_rsp_valid,
    input  logic      rsp_nonzero,
    input  logic      bo_expired,
    output lock_req_t req,
    output logic      grant,
    output logic      lock_held,
    output logic      bo_restart,
    output logic      bo_fail,
    output logic      bo_pausing
);
    lk_state_e state_q, next_st;
    logic      grant_q;

    always_comb begin
        next_st    = state_q;
        bo_restart = 1'b0;
        bo_fail    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (acq_req) begin
                next_st    = ST_POLL_REQ;
                bo_restart = 1'b1;
            end
            ST_POLL_REQ: if (mem_req_ready) next_st = ST_POLL_WAIT;
            ST_POLL_WAIT: if (mem_rsp_valid) begin
                if (rsp_nonzero) begin next_st = ST_PAUSE; bo_fail = 1'b1; end
                else              next_st = ST_SWAP_REQ;
            end
            ST_SWAP_REQ: if (mem_req_ready) next_st = ST_SWAP_WAIT;
            ST_SWAP_WAIT: if (mem_rsp_valid) begin
                if (rsp_nonzero) begin next_st = ST_PAUSE; bo_fail = 1'b1; end
                else begin next_st = ST_OWNED; bo_restart = 1'b1; end
            end
            ST_PAUSE: if (bo_expired) next_st = ST_POLL_REQ;
            ST_OWNED: if (rel_req) next_st = ST_FREE_REQ;
            ST_FREE_REQ: if (mem_req_ready) next_st = ST_FREE_WAIT;
            ST_FREE_WAIT: if (mem_rsp_valid) next_st = ST_IDLE;
            default: next_st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grant_q <= 1'b0;
        end else begin
            state_q <= next_st;
            grant_q <= (state_q == ST_SWAP_WAIT) && mem_rsp_valid && !rsp_nonzero;
        end
    end

    assign req        = req_for_state(state_q);
    assign grant      = grant_q;
    assign lock_held  = (state_q == ST_OWNED);
    assign bo_pausing = (state_q == ST_PAUSE);

    logic swap_issue, free_issue;
    assign swap_issue = req.valid && (req.op == MEM_XCHG);
    assign free_issue = req.valid && (req.op == MEM_WRITE);

    assert_grant_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        grant |=> !grant);

    assert_grant_owned_R4: assert property (@(posedge clk) disable iff (rst)
        grant |-> lock_held);

    assert_swap_after_free_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(swap_issue) |-> $past(mem_rsp_valid && !rsp_nonzero));

    assert_release_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(free_issue) |-> $past(rel_req && lock_held));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (req.valid && !mem_req_ready) |=> (req.valid && $stable(req.op)));

endmodule

// File: rtl/spin_lock_requester.sv
module spin_lock_requester
    import spinlock_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 32,
    parameter int                CNT_W     = 8,
    parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'h0040
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acq_req,
    input  logic              rel_req,
    input  logic [CNT_W-1:0]  bo_min,
    input  logic [CNT_W-1:0]  bo_max,
    output logic              grant,
    output logic              lock_held,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [1:0]        mem_req_op,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    lock_req_t req;
    logic      rsp_nonzero;
    logic      bo_restart, bo_fail, bo_pausing, bo_expired;

    assign rsp_nonzero = |mem_rsp_data;

    spl_ctrl ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .acq_req       (acq_req),
        .rel_req       (rel_req),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_nonzero   (rsp_nonzero),
        .bo_expired    (bo_expired),
        .req           (req),
        .grant         (grant),
        .lock_held     (lock_held),
        .bo_restart    (bo_restart),
        .bo_fail       (bo_fail),
        .bo_pausing    (bo_pausing)
    );

    spl_backoff #(.CNT_W(CNT_W)) backoff_i (
        .clk     (clk),
        .rst     (rst),
        .bo_min  (bo_min),
        .bo_max  (bo_max),
        .restart (bo_restart),
        .fail    (bo_fail),
        .pausing (bo_pausing),
        .expired (bo_expired)
    );

    assign mem_req_valid = req.valid;
    assign mem_req_op    = req.op;
    assign mem_req_addr  = LOCK_ADDR;
    assign mem_req_wdata = {{(DATA_W-1){1'b0}}, req.set_one};

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (!grant && !lock_held && !mem_req_valid));

endmodule

// File: tb/spin_lock_requester_tb_top.sv
`timescale 1ns/1ps
module spin_lock_requester_tb_top;
    import spinlock_pkg::*;

    localparam int                ADDR_W = 12;
    localparam int                DATA_W = 16;
    localparam int                CNT_W  = 5;
    localparam logic [ADDR_W-1:0] LADDR  = 12'h3A0;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acq_req = 1'b0, rel_req = 1'b0;
    logic [CNT_W-1:0]  bo_min = 5'd1, bo_max = 5'd4;
    logic              grant, lock_held;
    logic              mem_req_valid, mem_req_ready = 1'b0;
    logic [1:0]        mem_req_op;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0] mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    spin_lock_requester #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .LOCK_ADDR(LADDR)) dut_i (
        .clk(clk), .rst(rst), .acq_req(acq_req), .rel_req(rel_req),
        .bo_min(bo_min), .bo_max(bo_max), .grant(grant), .lock_held(lock_held),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_op(mem_req_op),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural memory state, shared with the stimulus tasks
    logic [DATA_W-1:0] mem_word = '0;
    int  hold_left = 0, steal_left = 0;
    int  cyc = 0, req_count = 0, grant_count = 0;
    int  exp_iv = 0, exp_wait = 0, fail_t = 0, swap_ok_t = -10;
    bit  fail_pend = 0, first_fail = 0, first_req = 0, last_read_zero = 0;

    function automatic int next_iv(int iv, int mx);
        return (2 * iv > mx) ? mx : 2 * iv;
    endfunction

    initial begin : mem_model
        bit       acc_pend = 0, prev_valid = 0, prev_hs = 1, prev_grant = 0;
        logic [1:0]        pend_op = '0, prev_op = '0;
        logic [DATA_W-1:0] pend_wd = '0, old;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst) begin
                acc_pend = 0; prev_valid = 0; prev_hs = 1; mem_rsp_valid = 1'b0;
                continue;
            end
            mem_rsp_valid = 1'b0;
            if (hold_left > 0) begin
                hold_left--;
                if (hold_left == 0) mem_word = '0;
            end
            if (acc_pend) begin
                acc_pend = 0;
                old = mem_word;
                if (pend_op == MEM_READ) begin
                    last_read_zero = (old == '0);
                end else if (pend_op == MEM_XCHG) begin
                    chk(last_read_zero, "R3 exchange follows a free read", last_read_zero, 1);
                    chk(pend_wd == 1, "R3 exchange data", pend_wd, 1);
                    if (old == '0 && steal_left > 0) begin
                        steal_left--;
                        old = 1;
                        hold_left = 1 + int'($urandom % 20);
                    end
                    mem_word = pend_wd;
                    if (old == '0) swap_ok_t = cyc;
                    last_read_zero = 0;
                end else begin
                    chk(pend_wd == 0, "R8 release writes free", pend_wd, 0);
                    mem_word = pend_wd;
                    old = '0;
                end
                mem_rsp_data  = old;
                mem_rsp_valid = 1'b1;
                if (pend_op != MEM_WRITE && old != '0) begin
                    fail_t    = cyc;
                    exp_wait  = (exp_iv < 1) ? 1 : exp_iv;
                    exp_iv    = next_iv(exp_iv, int'(bo_max));
                    fail_pend = 1;
                end
            end
            if (grant) begin
                grant_count++;
                chk(cyc == swap_ok_t + 1, "R4 grant timing", cyc, swap_ok_t + 1);
                chk(lock_held, "R4 held with grant", lock_held, 1);
                chk(!prev_grant, "R4 grant one cycle", prev_grant, 0);
            end
            prev_grant = grant;
            if (mem_req_valid && (mem_rsp_valid || acc_pend))
                chk(0, "R10 request while response owed", 1, 0);
            if (prev_valid && !prev_hs)
                chk(mem_req_valid && mem_req_op == prev_op, "R10 request held", mem_req_op, prev_op);
            if (mem_req_valid && !prev_valid && fail_pend) begin
                fail_pend = 0;
                if (first_fail) begin
                    first_fail = 0;
                    chk(cyc - fail_t == exp_wait + 1, "R7 first wait is minimum", cyc - fail_t, exp_wait + 1);
                end else begin
                    chk(cyc - fail_t == exp_wait + 1, "R5 R6 backoff gap", cyc - fail_t, exp_wait + 1);
                end
                chk(mem_req_op == MEM_READ, "R5 retry is a read", mem_req_op, MEM_READ);
            end
            mem_req_ready = ($urandom % 4) != 0;
            if (mem_req_valid && mem_req_ready) begin
                acc_pend = 1; pend_op = mem_req_op; pend_wd = mem_req_wdata;
                req_count++;
                chk(mem_req_addr == LADDR, "R2 lock address", mem_req_addr, LADDR);
                if (first_req) begin
                    first_req = 0;
                    chk(mem_req_op == MEM_READ, "R2 first op is read", mem_req_op, MEM_READ);
                end
            end
            prev_valid = mem_req_valid; prev_op = mem_req_op; prev_hs = mem_req_valid && mem_req_ready;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic run_acquire(int mn, int mx, int hold, int steal);
        int g0, t;
        bo_min = CNT_W'(mn); bo_max = CNT_W'(mx);
        mem_word = (hold > 0) ? 1 : 0;
        hold_left = hold; steal_left = steal;
        exp_iv = mn; fail_pend = 0; first_fail = 1; first_req = 1;
        g0 = grant_count;
        acq_req = 1'b1; tick(1); acq_req = 1'b0;
        t = 0;
        while (grant_count == g0 && t < 4000) begin tick(1); t++; end
        chk(grant_count == g0 + 1, "R4 acquire granted", grant_count - g0, 1);
        tick(1);
        chk(lock_held && mem_word == 1, "R4 lock owned", lock_held, 1);
    endtask

    task automatic run_release();
        int t;
        rel_req = 1'b1; tick(1); rel_req = 1'b0;
        chk(!lock_held, "R8 held drops after release", lock_held, 0);
        t = 0;
        while (mem_word != 0 && t < 200) begin tick(1); t++; end
        chk(mem_word == 0, "R8 lock word freed", mem_word, 0);
        tick(4);
    endtask

    initial begin : main
        int rc;
        void'($urandom(32'h5A17));
        tick(4);
        rst = 1'b0;
        chk(!grant && !lock_held && !mem_req_valid, "R1 reset outputs", {grant, lock_held, mem_req_valid}, 0);

        // free lock, no contention
        run_acquire(1, 4, 0, 0);
        // R9: acquire ignored while owned
        rc = req_count;
        acq_req = 1'b1; tick(1); acq_req = 1'b0; tick(10);
        chk(req_count == rc && lock_held, "R9 acquire ignored while owned", req_count - rc, 0);
        run_release();
        // R9: release ignored while idle
        rc = req_count;
        rel_req = 1'b1; tick(1); rel_req = 1'b0; tick(10);
        chk(req_count == rc && !lock_held, "R9 release ignored while idle", req_count - rc, 0);

        // saturation at a ceiling below the counter top (R6)
        run_acquire(3, 20, 150, 0);
        run_release();
        // doubling beyond counter width clamps (R6), then minimum again (R7)
        run_acquire(24, 31, 200, 1);
        run_release();
        run_acquire(2, 31, 40, 0);
        run_release();
        // lost race at the exchange (R5)
        run_acquire(1, 8, 0, 2);
        run_release();

        for (int k = 0; k < 30; k++) begin
            int mn, mx;
            mn = 1 + int'($urandom % 4);
            mx = mn + int'($urandom % (32 - mn));
            run_acquire(mn, mx, int'($urandom % 80), int'($urandom % 3));
            tick(int'($urandom % 8));
            run_release();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule